// File: doc/BRIEF.md
# Fixed-Address Two-Wire Configuration Register Slave

This block lets an external two-wire bus master read and write a bank of 128 byte-wide configuration registers. It answers to one hard-wired 7-bit device address, `0x5F`. The full address byte is `0xBE` for a write and `0xBF` for a read.

A write transfer carries the address byte, then a register index byte, then any number of data bytes. A read sets the index with a write transfer, then issues a repeated START followed by the read address byte. The register pointer advances after every data byte, whether it was written or read, and wraps from 127 back to 0.

One bit of the bank, bit 0 of register 1, acts as a run control for the rest of the device. The bus can set it, but only reset clears it. The other bits of that register, and every other register, stay writable after the run bit is set.

SCL and SDA are sampled by the system clock through two-stage synchronisers. SDA is driven open-drain: the block only ever pulls the line low.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, `run_flag` is 0, `sda_pull` is 0 and every register reads back as 0x00.
- R2: Only the address byte whose upper seven bits equal 0x5F is acknowledged. On any other address the slave leaves SDA released through the ninth clock and ignores every byte until the next START, so register contents do not change.
- R3: After the write address 0xBE, the slave acknowledges the register index byte and every data byte by holding SDA low (ack bit reads 0) during the ninth clock, and stores each data byte at the current pointer.
- R4: After a repeated START with the read address 0xBF, the slave shifts out the register at the current pointer MSB first, one bit per SCL low phase.
- R5: The pointer increments by one after each data byte written or read, and index 127 is followed by index 0.
- R6: Writing a 1 to register 1 bit 0 sets `run_flag`. A later write with bit 0 equal to 0 leaves it at 1, while bits 7..1 of register 1 take the written value.
- R7: With `run_flag` set, writes to other registers still take effect.
- R8: During a read the slave releases SDA for the ninth clock. When the master answers with a NACK (SDA high), the slave stops driving data, and a following STOP leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| run_flag | output | 1 | Register 1 bit 0, set-only from the bus |

## Verification
The hardest cases to reach from the pins are the edges of the byte framing.

The first is a repeated START that arrives right after a write acknowledge. It produces an extra SCL rising edge that must not shift the next byte's bit count. The bench builds a genuine open-drain bus, a wired AND of the master's SDA and the slave's pull, and issues the repeated START with the same timing a real master would, so that stray edge is present.

The second is the wrap of the pointer and the master NACK at the end of a read. Both are reached by writing across index 127 and then ending multi-byte reads with a NACK before STOP.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h5F,
  parameter int NREGS   = 128,
  parameter int RUN_REG = 1,
  parameter int RUN_BIT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  output logic run_flag
);
  localparam int AW = $clog2(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WR, S_RD} st_t;

  st_t          st;
  logic [2:0]   scl_p, sda_p;
  logic [3:0]   cnt;
  logic [7:0]   sh;
  logic [AW-1:0] ptr;
  logic         nack;
  logic [7:0]   regs [NREGS];

  wire scl_q = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_q = sda_p[1];
  wire sda_d = sda_p[2];
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire bus_start = scl_q & scl_d & sda_d & ~sda_q;
  wire bus_stop  = scl_q & scl_d & ~sda_d & sda_q;
  wire [2:0] bidx = 3'(4'd7 - cnt);

  assign run_flag = regs[RUN_REG][RUN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      nack     <= 1'b0;
      sda_pull <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (bus_start) begin
      st       <= S_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8 && st != S_RD) sh <= {sh[6:0], sda_q};
        if (cnt == 4'd8) nack <= sda_q;
        cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            S_ADDR: begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                st <= sh[0] ? S_RD : S_REG;
              end else begin
                st <= S_IDLE;
              end
            end
            S_REG: begin
              ptr      <= sh[AW-1:0];
              sda_pull <= 1'b1;
              st       <= S_WR;
            end
            S_WR: begin
              regs[ptr] <= sh;
              if (ptr == AW'(RUN_REG))
                regs[ptr][RUN_BIT] <= sh[RUN_BIT] | regs[ptr][RUN_BIT];
              ptr      <= ptr + 1'b1;
              sda_pull <= 1'b1;
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (st == S_RD && !nack) begin
            sh       <= regs[ptr];
            sda_pull <= ~regs[ptr][7];
            ptr      <= ptr + 1'b1;
          end else begin
            sda_pull <= 1'b0;
            if (st == S_RD) st <= S_IDLE;
          end
        end else if (st == S_RD && cnt != 4'd0) begin
          sda_pull <= ~sh[bidx];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic run_flag
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!run_flag && !sda_pull)); // R1
  AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull) |-> !scl_in); // R3
  AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_pull) |-> !scl_in); // R8
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) run_flag |=> run_flag); // R6
  AST_RUN_SET_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(run_flag) |-> !scl_in); // R6
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull), .run_flag(run_flag)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, run_flag;
  wire  sda_bus = sda_m & ~sda_pull;

  int checks = 0, failures = 0;
  bit done = 0;
  string    exp_tag[$];
  logic [7:0] exp_val[$];
  logic [7:0] obs_val[$];

  always #5 clk = ~clk;

  i2c_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .run_flag(run_flag)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, expv);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (obs_val.size() > 0 && exp_val.size() > 0)
        check(exp_tag.pop_front(), obs_val.pop_front(), exp_val.pop_front());
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic put(string tag, logic [7:0] v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic tx(string tag, logic [7:0] b, logic exp_ack_bit);
    logic a;
    put(tag, {7'd0, exp_ack_bit});
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_bit(a);
    obs_val.push_back({7'd0, a});
  endtask

  task automatic rx(string tag, logic [7:0] expv, logic last);
    logic [7:0] v;
    logic b;
    put(tag, expv);
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    send_bit(last);
    obs_val.push_back(v);
  endtask

  task automatic set_ptr(string tag, logic [7:0] idx);
    bus_start; tx(tag, 8'hBE, 1'b0); tx(tag, idx, 1'b0);
  endtask

  task automatic write2(string tag, logic [7:0] idx, logic [7:0] d0, logic [7:0] d1);
    set_ptr(tag, idx); tx(tag, d0, 1'b0); tx(tag, d1, 1'b0); bus_stop;
  endtask

  task automatic write1(string tag, logic [7:0] idx, logic [7:0] d0);
    set_ptr(tag, idx); tx(tag, d0, 1'b0); bus_stop;
  endtask

  task automatic read2(string tag, logic [7:0] idx, logic [7:0] e0, logic [7:0] e1);
    set_ptr(tag, idx); bus_start; tx(tag, 8'hBF, 1'b0);
    rx(tag, e0, 1'b0); rx(tag, e1, 1'b1);
    check({tag, " R8 released after NACK"}, {7'd0, sda_pull}, 8'h00);
    bus_stop;
  endtask

  task automatic read1(string tag, logic [7:0] idx, logic [7:0] e0);
    set_ptr(tag, idx); bus_start; tx(tag, 8'hBF, 1'b0);
    rx(tag, e0, 1'b1); bus_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end

  initial begin : driver
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R1 run_flag after reset", {7'd0, run_flag}, 8'h00);
    check("R1 sda_pull after reset", {7'd0, sda_pull}, 8'h00);
    read1("R1 reset value", 8'd20, 8'h00);

    write2("R3 write", 8'd5, 8'hA5, 8'h3C);
    read2("R4 R5 read back", 8'd5, 8'hA5, 8'h3C);

    bus_start; tx("R2 wrong write addr", 8'hBC, 1'b1);
    tx("R2 ignored byte", 8'h05, 1'b1); tx("R2 ignored byte", 8'hFF, 1'b1); bus_stop;
    bus_start; tx("R2 wrong read addr", 8'hA1, 1'b1); bus_stop;
    read1("R2 unchanged", 8'd5, 8'hA5);

    write2("R5 wrap write", 8'd127, 8'h11, 8'h22);
    read2("R5 wrap read", 8'd127, 8'h11, 8'h22);

    check("R6 run_flag before set", {7'd0, run_flag}, 8'h00);
    write1("R6 set run", 8'd1, 8'h01);
    check("R6 run_flag set", {7'd0, run_flag}, 8'h01);
    write1("R6 clear attempt", 8'd1, 8'hF0);
    check("R6 run_flag sticky", {7'd0, run_flag}, 8'h01);
    read1("R6 reg1 value", 8'd1, 8'hF1);

    write1("R7 write after run", 8'd10, 8'h77);
    read2("R7 read after run", 8'd10, 8'h77, 8'h00);

    tick(20);
    check("R8 idle release", {7'd0, sda_pull}, 8'h00);
    if (exp_val.size() != 0 || obs_val.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_val.size());
    end
    finish_run;
  end
endmodule